// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns a single 8-bit operation code, written by a host, into the series of byte cycles that a NAND flash expects. Each byte cycle is either a command latch or an address latch. Depending on the code, the block sends one command byte, or a command followed by address bytes. Longer codes add a second command, a wait for the flash ready/busy line, and a start pulse to an external data-transfer engine, after which the block waits for that engine to report completion.

The address bytes come from a small internal bank of registers that the host loads through a write port. There are four banks of sixteen bytes each, and a 2-bit select input picks the bank. A 2-bit mode input sets how many address cycles are sent and which bank offsets they come from. Bank select and mode are captured when a code is accepted. Every byte cycle is handed to a separate strobe/timing engine through a valid/ready handshake.

A busy output tells the host when a sequence is running. A reset code of FF is always honoured, even in the middle of a sequence.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, busy, cyc_valid and dma_start are all 0.
- R2: The addr_mode input sets the address cycles. Mode 00 sends bank offsets 0,1,2,3,4. Mode 01 sends offsets 0,2,3,4. Mode 10 sends offsets 0,2,3. The bytes are sent in that order, and each one has cyc_is_addr=1.
- R3: Address bytes come from the bank that bank_sel named when the code was accepted. Bank byte (b,o) is written at bank_waddr = b*16+o. Changing bank_sel after acceptance has no effect on the running sequence.
- R4: Codes 00, 01, 50, 60 and 80 send that same byte as a command cycle (cyc_is_addr=0), followed by the address cycles.
- R5: Codes 10, 30, 70, 90 and D0 send only that byte as a single command cycle.
- R6: Code FB sends command 00, then the address cycles, then command 30. It then waits until rb_ready is 1, and only then gives one dma_start pulse with dma_write=0.
- R7: Code F7 sends command 05, then the address cycles, then command E0, then a dma_start pulse with dma_write=0. It does not wait on rb_ready.
- R8: Code FE sends command 80 and code FD sends command 85. Each is followed by the address cycles and then a dma_start pulse with dma_write=1.
- R9: Code FF is accepted even while busy. It abandons any running sequence and sends the single command FF.
- R10: Codes not listed in R4 to R9 are ignored, and busy stays 0. Any code other than FF that arrives while busy is ignored.
- R11: When addr_mode is 11, codes that carry address cycles are ignored. Codes without address cycles are still run.
- R12: busy is 1 from the cycle after acceptance. It returns to 0 in the cycle after the last byte handshake, or after dma_done for codes that use the transfer engine.
- R13: While cyc_valid is 1 and cyc_ready is 0, cyc_valid, cyc_data and cyc_is_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Host writes an operation code this cycle |
| op_code | input | 8 | Operation code |
| addr_mode | input | 2 | Address cycle count select |
| bank_sel | input | 2 | Address bank select |
| bank_we | input | 1 | Address bank write enable |
| bank_waddr | input | 6 | Address bank write location (bank*16+offset) |
| bank_wdata | input | 8 | Address bank write data |
| busy | output | 1 | Sequence in progress |
| cyc_valid | output | 1 | Byte cycle request to the strobe engine |
| cyc_ready | input | 1 | Strobe engine accepts the byte cycle |
| cyc_is_addr | output | 1 | 1 = address latch, 0 = command latch |
| cyc_data | output | 8 | Byte to place on the flash bus |
| rb_ready | input | 1 | Flash ready/busy line, 1 = ready |
| dma_start | output | 1 | One-cycle start pulse to the transfer engine |
| dma_write | output | 1 | Transfer direction with dma_start, 1 = write to flash |
| dma_done | input | 1 | Transfer engine finished |

## Verification
Each address mode is run with several codes and banks, so that a wrong offset skip, a wrong cycle count or a wrong bank latch shows up as a mismatched byte. The strobe engine's ready is run both always-high and alternating, which separates correct handshake hold from a sequencer that advances without acceptance. The multi-step codes are run with ready/busy held low: FB must stall before its transfer while F7 must not. Unknown codes, reserved-mode codes, codes written while busy, and an FF abort in the middle of a wait each produce either no byte cycles at all or exactly the single FF cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD1,
        PH_ADDR,
        PH_CMD2,
        PH_WAIT,
        PH_DMA_GO,
        PH_DMA_RUN
    } phase_t;

    typedef struct packed {
        logic              known;
        logic [BYTE_W-1:0] cmd1;
        logic              use_addr;
        logic              use_cmd2;
        logic [BYTE_W-1:0] cmd2;
        logic              wait_rb;
        logic              use_dma;
        logic              dma_wr;
    } prog_t;

    localparam logic [BYTE_W-1:0] OP_RESET = 8'hFF;

    function automatic prog_t decode_op(input logic [BYTE_W-1:0] code);
        prog_t p;
        p = '0;
        p.cmd1 = code;
        unique case (code)
            8'h00, 8'h01, 8'h50, 8'h60, 8'h80: begin
                p.known    = 1'b1;
                p.use_addr = 1'b1;
            end
            8'h10, 8'h30, 8'h70, 8'h90, 8'hD0, 8'hFF: begin
                p.known = 1'b1;
            end
            8'hFB: begin
                p.known    = 1'b1;
                p.cmd1     = 8'h00;
                p.use_addr = 1'b1;
                p.use_cmd2 = 1'b1;
                p.cmd2     = 8'h30;
                p.wait_rb  = 1'b1;
                p.use_dma  = 1'b1;
            end
            8'hF7: begin
                p.known    = 1'b1;
                p.cmd1     = 8'h05;
                p.use_addr = 1'b1;
                p.use_cmd2 = 1'b1;
                p.cmd2     = 8'hE0;
                p.use_dma  = 1'b1;
            end
            8'hFE, 8'hFD: begin
                p.known    = 1'b1;
                p.cmd1     = (code == 8'hFE) ? 8'h80 : 8'h85;
                p.use_addr = 1'b1;
                p.use_dma  = 1'b1;
                p.dma_wr   = 1'b1;
            end
            default: p.known = 1'b0;
        endcase
        return p;
    endfunction

    function automatic logic [IDX_W-1:0] addr_count(input logic [1:0] mode);
        unique case (mode)
            2'b00:   return 3'd5;
            2'b01:   return 3'd4;
            2'b10:   return 3'd3;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] addr_offset(input logic [1:0] mode,
                                                     input logic [IDX_W-1:0] idx);
        if (mode == 2'b00 || idx == '0)
            return idx;
        return idx + 3'd1;
    endfunction

endpackage

// File: rtl/nand_addr_bank.sv
module nand_addr_bank #(
    parameter int BANKS      = 4,
    parameter int BANK_BYTES = 16,
    localparam int BANK_AW   = $clog2(BANKS),
    localparam int OFS_AW    = $clog2(BANK_BYTES),
    localparam int DEPTH     = BANKS * BANK_BYTES
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [BANK_AW+OFS_AW-1:0] waddr,
    input  logic [7:0]                wdata,
    input  logic [BANK_AW-1:0]        rd_bank,
    input  logic [OFS_AW-1:0]         rd_ofs,
    output logic [7:0]                rd_data
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rd_data = store[{rd_bank, rd_ofs}];
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_seq_pkg::*;
#(
    parameter int BANK_AW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [7:0]         op_code,
    input  logic [1:0]         mode_in,
    input  logic [BANK_AW-1:0] bank_in,
    input  logic               hs,
    input  logic               rb_ready,
    input  logic               dma_done,
    output phase_t             phase,
    output prog_t              prog,
    output logic [IDX_W-1:0]   addr_idx,
    output logic [1:0]         lat_mode,
    output logic [BANK_AW-1:0] lat_bank,
    output logic               busy,
    output logic               dma_start,
    output logic               dma_write
);
    prog_t  dec;
    logic   mode_ok;
    logic   accept;
    logic   last_addr;
    phase_t after_cmd2;
    phase_t after_addr;
    phase_t after_cmd1;

    assign dec       = decode_op(op_code);
    assign mode_ok   = !(dec.use_addr && mode_in == 2'b11);
    assign accept    = op_valid && dec.known && mode_ok &&
                       (phase == PH_IDLE || op_code == OP_RESET);
    assign last_addr = (addr_idx == addr_count(lat_mode) - 3'd1);

    always_comb begin
        if (prog.wait_rb)      after_cmd2 = PH_WAIT;
        else if (prog.use_dma) after_cmd2 = PH_DMA_GO;
        else                   after_cmd2 = PH_IDLE;
        after_addr = prog.use_cmd2 ? PH_CMD2 : after_cmd2;
        after_cmd1 = prog.use_addr ? PH_ADDR : after_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            prog     <= '0;
            addr_idx <= '0;
            lat_mode <= '0;
            lat_bank <= '0;
        end else if (accept) begin
            phase    <= PH_CMD1;
            prog     <= dec;
            addr_idx <= '0;
            lat_mode <= mode_in;
            lat_bank <= bank_in;
        end else begin
            unique case (phase)
                PH_CMD1:    if (hs) phase <= after_cmd1;
                PH_ADDR: begin
                    if (hs) begin
                        if (last_addr) phase <= after_addr;
                        else           addr_idx <= addr_idx + 3'd1;
                    end
                end
                PH_CMD2:    if (hs) phase <= after_cmd2;
                PH_WAIT:    if (rb_ready) phase <= prog.use_dma ? PH_DMA_GO : PH_IDLE;
                PH_DMA_GO:  phase <= PH_DMA_RUN;
                PH_DMA_RUN: if (dma_done) phase <= PH_IDLE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign dma_start = (phase == PH_DMA_GO);
    assign dma_write = prog.dma_wr;
endmodule

// File: rtl/nand_cycle_mux.sv
module nand_cycle_mux
    import nand_seq_pkg::*;
(
    input  phase_t     phase,
    input  prog_t      prog,
    input  logic [7:0] addr_byte,
    output logic       cyc_valid,
    output logic       cyc_is_addr,
    output logic [7:0] cyc_data
);
    always_comb begin
        cyc_valid   = 1'b0;
        cyc_is_addr = 1'b0;
        cyc_data    = '0;
        unique case (phase)
            PH_CMD1: begin
                cyc_valid = 1'b1;
                cyc_data  = prog.cmd1;
            end
            PH_ADDR: begin
                cyc_valid   = 1'b1;
                cyc_is_addr = 1'b1;
                cyc_data    = addr_byte;
            end
            PH_CMD2: begin
                cyc_valid = 1'b1;
                cyc_data  = prog.cmd2;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int BANKS      = 4,
    parameter int BANK_BYTES = 16,
    localparam int BANK_AW   = $clog2(BANKS),
    localparam int OFS_AW    = $clog2(BANK_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      op_valid,
    input  logic [7:0]                op_code,
    input  logic [1:0]                addr_mode,
    input  logic [BANK_AW-1:0]        bank_sel,
    input  logic                      bank_we,
    input  logic [BANK_AW+OFS_AW-1:0] bank_waddr,
    input  logic [7:0]                bank_wdata,
    output logic                      busy,
    output logic                      cyc_valid,
    input  logic                      cyc_ready,
    output logic                      cyc_is_addr,
    output logic [7:0]                cyc_data,
    input  logic                      rb_ready,
    output logic                      dma_start,
    output logic                      dma_write,
    input  logic                      dma_done
);
    phase_t             phase;
    prog_t              prog;
    logic [IDX_W-1:0]   addr_idx;
    logic [1:0]         lat_mode;
    logic [BANK_AW-1:0] lat_bank;
    logic [OFS_AW-1:0]  rd_ofs;
    logic [7:0]         addr_byte;

    assign rd_ofs = OFS_AW'(addr_offset(lat_mode, addr_idx));

    nand_addr_bank #(.BANKS(BANKS), .BANK_BYTES(BANK_BYTES)) u_bank (
        .clk     (clk),
        .we      (bank_we),
        .waddr   (bank_waddr),
        .wdata   (bank_wdata),
        .rd_bank (lat_bank),
        .rd_ofs  (rd_ofs),
        .rd_data (addr_byte)
    );

    nand_seq_ctrl #(.BANK_AW(BANK_AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .mode_in   (addr_mode),
        .bank_in   (bank_sel),
        .hs        (cyc_valid && cyc_ready),
        .rb_ready  (rb_ready),
        .dma_done  (dma_done),
        .phase     (phase),
        .prog      (prog),
        .addr_idx  (addr_idx),
        .lat_mode  (lat_mode),
        .lat_bank  (lat_bank),
        .busy      (busy),
        .dma_start (dma_start),
        .dma_write (dma_write)
    );

    nand_cycle_mux u_mux (
        .phase       (phase),
        .prog        (prog),
        .addr_byte   (addr_byte),
        .cyc_valid   (cyc_valid),
        .cyc_is_addr (cyc_is_addr),
        .cyc_data    (cyc_data)
    );
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker
    import nand_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic       busy,
    input logic       cyc_valid,
    input logic       cyc_ready,
    input logic       cyc_is_addr,
    input logic [7:0] cyc_data,
    input logic       dma_start
);
    logic ff_now;
    assign ff_now = op_valid && op_code == OP_RESET;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && !cyc_ready && !ff_now |=>
            cyc_valid && $stable(cyc_data) && $stable(cyc_is_addr)); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cyc_valid && !dma_start); // R12

    AST_DMA_PULSE: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start); // R8

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !busy && op_valid && !decode_op(op_code).known |=> !busy); // R10

    AST_RESET_CODE: assert property (@(posedge clk) disable iff (rst)
        ff_now |=> cyc_valid && !cyc_is_addr && cyc_data == 8'hFF); // R9
endmodule

bind nand_seq_top nand_seq_checker u_seq_checker (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .busy        (busy),
    .cyc_valid   (cyc_valid),
    .cyc_ready   (cyc_ready),
    .cyc_is_addr (cyc_is_addr),
    .cyc_data    (cyc_data),
    .dma_start   (dma_start)
);

// File: tb/test_nand_seq_top.sv
module test_nand_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = '0;
    logic [1:0] addr_mode = '0;
    logic [1:0] bank_sel = '0;
    logic       bank_we = 1'b0;
    logic [5:0] bank_waddr = '0;
    logic [7:0] bank_wdata = '0;
    logic       busy;
    logic       cyc_valid;
    logic       cyc_ready = 1'b1;
    logic       cyc_is_addr;
    logic [7:0] cyc_data;
    logic       rb_ready = 1'b1;
    logic       dma_start;
    logic       dma_write;
    logic       dma_done = 1'b0;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    stall   = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R1";
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    nand_seq_top i_nand_seq_top (.*);

    function automatic logic [7:0] bank_val(input int b, input int o);
        return 8'((b * 16 + o) * 7 + 3);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // strobe engine ready model
    initial forever begin
        @(negedge clk);
        cyc_ready = stall ? ~cyc_ready : 1'b1;
    end

    // transfer engine model
    initial forever begin
        @(negedge clk);
        dma_done = 1'b0;
        if (dma_start) begin
            repeat (3) @(negedge clk);
            dma_done = 1'b1;
        end
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        #3;
        if (!rst) begin
            if (cyc_valid && cyc_ready) begin
                if (exp_q.size() == 0)
                    check(1'b0, cur_req, "unexpected byte cycle", {cyc_is_addr, cyc_data}, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check(e == {1'b0, cyc_is_addr, cyc_data}, cur_req, "byte cycle",
                          {cyc_is_addr, cyc_data}, e);
                end
            end
            if (dma_start) begin
                if (exp_q.size() == 0)
                    check(1'b0, cur_req, "unexpected dma_start", dma_write, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check(e == {1'b1, dma_write, 8'h00}, cur_req, "dma start",
                          {1'b1, dma_write, 8'h00}, e);
                end
            end
        end
    end

    task automatic push_addr(input int mode, input int bank);
        int cnt;
        cnt = 5 - mode;
        for (int i = 0; i < cnt; i++) begin
            int o;
            o = (mode == 0 || i == 0) ? i : i + 1;
            exp_q.push_back({2'b01, bank_val(bank, o)});
        end
    endtask

    task automatic push_expected(input logic [7:0] code, input int mode, input int bank);
        case (code)
            8'h00, 8'h01, 8'h50, 8'h60, 8'h80: begin
                exp_q.push_back({2'b00, code});
                push_addr(mode, bank);
            end
            8'hFB: begin
                exp_q.push_back({2'b00, 8'h00}); push_addr(mode, bank);
                exp_q.push_back({2'b00, 8'h30}); exp_q.push_back({2'b10, 8'h00});
            end
            8'hF7: begin
                exp_q.push_back({2'b00, 8'h05}); push_addr(mode, bank);
                exp_q.push_back({2'b00, 8'hE0}); exp_q.push_back({2'b10, 8'h00});
            end
            8'hFE, 8'hFD: begin
                exp_q.push_back({2'b00, (code == 8'hFE) ? 8'h80 : 8'h85});
                push_addr(mode, bank);
                exp_q.push_back({2'b11, 8'h00});
            end
            default: exp_q.push_back({2'b00, code});
        endcase
    endtask

    task automatic drive_op(input logic [7:0] code, input int mode, input int bank);
        @(negedge clk);
        op_code   = code;
        addr_mode = 2'(mode);
        bank_sel  = 2'(bank);
        op_valid  = 1'b1;
        @(negedge clk);
        op_valid  = 1'b0;
        bank_sel  = 2'(bank) ^ 2'b01;
        addr_mode = 2'(mode) ^ 2'b01;
    endtask

    task automatic start_op(input logic [7:0] code, input int mode, input int bank,
                            input string req);
        cur_req = req;
        push_expected(code, mode, bank);
        drive_op(code, mode, bank);
        #4;
        check(busy === 1'b1, "R12", "busy after accept", busy, 1);
    endtask

    task automatic finish_op(input string req);
        for (int k = 0; k < 300; k++) begin
            if (!busy) break;
            @(negedge clk);
            #4;
        end
        check(busy === 1'b0, "R12", "busy cleared at end", busy, 0);
        check(exp_q.size() == 0, req, "items left in queue", exp_q.size(), 0);
    endtask

    task automatic run_op(input logic [7:0] code, input int mode, input int bank,
                          input string req);
        start_op(code, mode, bank, req);
        finish_op(req);
    endtask

    task automatic ignored_op(input logic [7:0] code, input int mode, input string req);
        cur_req = req;
        drive_op(code, mode, 0);
        #4;
        check(busy === 1'b0, req, "busy after ignored code", busy, 0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && busy === 1'b0, req, "ignored code produced activity",
              busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        check(busy === 1'b0 && cyc_valid === 1'b0 && dma_start === 1'b0, "R1",
              "reset state", {busy, cyc_valid, dma_start}, 0);

        for (int b = 0; b < 4; b++)
            for (int o = 0; o < 16; o++) begin
                @(negedge clk);
                bank_we    = 1'b1;
                bank_waddr = 6'(b * 16 + o);
                bank_wdata = bank_val(b, o);
            end
        @(negedge clk);
        bank_we = 1'b0;

        // R4 R2 R3: plain codes with address cycles across modes and banks
        run_op(8'h00, 0, 0, "R4");
        run_op(8'h01, 1, 2, "R2");
        run_op(8'h50, 2, 1, "R3");
        stall = 1'b1;                     // R13: alternating ready
        run_op(8'h60, 1, 1, "R13");
        run_op(8'h80, 2, 3, "R2");
        stall = 1'b0;

        // R5: command-only codes
        run_op(8'h70, 0, 0, "R5");
        run_op(8'h90, 1, 0, "R5");
        run_op(8'hD0, 2, 0, "R5");
        run_op(8'h10, 0, 0, "R5");
        run_op(8'h30, 0, 0, "R5");

        // R6: FB waits for ready before the transfer start
        rb_ready = 1'b0;
        start_op(8'hFB, 0, 2, "R6");
        repeat (15) @(negedge clk);
        #4;
        check(busy === 1'b1 && exp_q.size() == 1, "R6", "waiting on ready/busy",
              exp_q.size(), 1);
        rb_ready = 1'b1;
        finish_op("R6");

        // R7: F7 does not wait on ready/busy
        rb_ready = 1'b0;
        stall = 1'b1;
        run_op(8'hF7, 1, 3, "R7");
        stall = 1'b0;
        rb_ready = 1'b1;

        // R8: write-transfer codes
        run_op(8'hFE, 0, 1, "R8");
        run_op(8'hFD, 2, 2, "R8");

        // R9: reset code from idle
        run_op(8'hFF, 0, 0, "R9");

        // R10 R11: ignored codes
        ignored_op(8'h42, 0, "R10");
        ignored_op(8'hED, 0, "R10");
        ignored_op(8'hFA, 1, "R10");
        ignored_op(8'h00, 3, "R11");
        ignored_op(8'hFB, 3, "R11");
        run_op(8'h70, 3, 0, "R11");

        // R10 while busy, then R9 abort
        rb_ready = 1'b0;
        start_op(8'hFB, 1, 0, "R9");
        repeat (12) @(negedge clk);
        cur_req = "R10";
        drive_op(8'h70, 0, 0);
        repeat (3) @(negedge clk);
        #4;
        check(busy === 1'b1 && exp_q.size() == 1, "R10", "code while busy not ignored",
              exp_q.size(), 1);
        exp_q.delete();
        start_op(8'hFF, 0, 0, "R9");
        finish_op("R9");
        rb_ready = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule